// File: doc/BRIEF.md
# AHB-Lite Burst-Splitting Bus Master

This block turns a word-level transfer request into legal AHB-Lite traffic that uses only four burst shapes: a single transfer, a 4-beat incrementing burst, an 8-beat incrementing burst and an 8-beat wrapping burst. A requester presents a start address, a word count, an access size, a direction and a transaction kind. The kind is one of plain access, cache linefill, half-line write-back or full-line write-back. The block chooses the burst shape from the kind. A plain request of any other length is cut greedily into supported pieces. The block also clears the low address bits to match the access size.

Write data is streamed in one word per accepted address beat. Read data is streamed out one word per completed data phase. A `done` pulse marks the completion of the final data phase. The state machine has three states. `ST_IDLE` waits for a request and leaves on *accept* (request valid while idle). `ST_ADDR` drives one address beat per cycle and stays there on *beat taken* while beats remain. It leaves on *last beat taken* (the final address phase is accepted) for `ST_DRAIN`. `ST_DRAIN` returns to `ST_IDLE` on *final data done*, which happens when HREADY is high during the last data phase. A new request is accepted only in `ST_IDLE`.

Top module: `burst_split_master`

## Requirements
- R1: During and right after reset, `htrans` is IDLE (2'b00), `req_ready` is 1 and `done` is 0.
- R2: A plain word request is split greedily. 8-beat INCR8 (3'b101) bursts are issued while at least 8 words remain, then 4-beat INCR4 (3'b011) bursts while at least 4 remain, then SINGLE (3'b000) transfers. No other `hburst` value is ever driven.
- R3: The first beat of every burst is NONSEQ (2'b10) and the later beats are SEQ (2'b11). Incrementing addresses advance by the access size in bytes (size code 0 = byte, 1 = halfword, 2 or 3 = word).
- R4: A linefill (kind 2'b01) is one WRAP8 (3'b100) word burst. It starts at the aligned critical word and wraps modulo 32 bytes inside its line, whatever the word count.
- R5: A half-line write-back (kind 2'b10) is one INCR4 word burst and a full-line write-back (kind 2'b11) is one INCR8 word burst, each starting at the aligned address; the word count is ignored.
- R6: Halfword addresses are driven with bit 0 cleared and word addresses with bits 1:0 cleared.
- R7: Byte and halfword plain accesses are always issued as SINGLE transfers with the matching `hsize`.
- R8: A request with `req_fetch` set is issued with word size (`hsize` 3'b010), whatever `req_size` says.
- R9: While HREADY is low, the address, all control outputs and `hwdata` hold their values.
- R10: `done` pulses only in the cycle in which the final data phase completes. `req_ready` is low from the cycle after acceptance until that point.
- R11: `wr_pull` is high exactly when a write address beat is accepted. The `wr_data` sampled then appears on `hwdata` for that beat's data phase.
- R12: For reads, `rd_valid` is high with `rd_data` equal to `hrdata` in each cycle in which a read data phase completes, and never for writes.
- R13: A plain request with a word count of 0 is performed as a 1-word request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_words | input | CNT_W | Number of beats for plain requests |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_kind | input | 2 | 0 plain, 1 linefill, 2 half-line write-back, 3 full-line write-back |
| req_fetch | input | 1 | Instruction fetch, forces word size |
| wr_data | input | 32 | Write word offered to the block |
| wr_pull | output | 1 | Write word taken this cycle |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word valid this cycle |
| done | output | 1 | Final data phase completed |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Transfer direction |
| hwdata | output | 32 | Write data |
| hrdata | input | 32 | Read data |
| hready | input | 1 | Transfer ready |

## Verification
The first address beat appears on the bus in the cycle after the request is taken at a clock edge. Each later beat follows one cycle after a clock edge at which HREADY was high. The data phase of a beat occupies the cycle after its address was accepted. `rd_valid` and `done` are combinational with HREADY inside that cycle. The bench drives HREADY and `hrdata` at the falling edge and samples all outputs shortly after. An address beat is compared against the scoreboard only when `htrans` is active with HREADY high. A data phase is compared only in the cycle after its address was taken and HREADY is high. A held beat is compared again one cycle later to confirm it did not move.

// File: rtl/ahbsplit_pkg.sv
package ahbsplit_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'b000,
        BU_INCR4  = 3'b011,
        BU_WRAP8  = 3'b100,
        BU_INCR8  = 3'b101
    } burst_e;

    typedef enum logic [1:0] {
        K_PLAIN  = 2'b00,
        K_FILL   = 2'b01,
        K_HALFWB = 2'b10,
        K_FULLWB = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DRAIN
    } state_e;

    localparam logic [2:0] SZ_BYTE = 3'b000;
    localparam logic [2:0] SZ_HALF = 3'b001;
    localparam logic [2:0] SZ_WORD = 3'b010;

    function automatic logic [3:0] burst_len(input burst_e b);
        unique case (b)
            BU_SINGLE: burst_len = 4'd1;
            BU_INCR4:  burst_len = 4'd4;
            BU_WRAP8:  burst_len = 4'd8;
            BU_INCR8:  burst_len = 4'd8;
            default:   burst_len = 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/addr_aligner.sv
module addr_aligner
    import ahbsplit_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] aligned_addr
);
    always_comb begin
        aligned_addr = raw_addr;
        unique case (size)
            SZ_BYTE: aligned_addr = raw_addr;
            SZ_HALF: aligned_addr = {raw_addr[ADDR_W-1:1], 1'b0};
            default: aligned_addr = {raw_addr[ADDR_W-1:2], 2'b00};
        endcase
    end
endmodule

// File: rtl/burst_planner.sv
module burst_planner
    import ahbsplit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] words_left,
    input  kind_e            kind,
    input  logic [2:0]       size,
    output burst_e           burst
);
    localparam logic [CNT_W-1:0] EIGHT = CNT_W'(8);
    localparam logic [CNT_W-1:0] FOUR  = CNT_W'(4);

    always_comb begin
        burst = BU_SINGLE;
        unique case (kind)
            K_FILL:   burst = BU_WRAP8;
            K_HALFWB: burst = BU_INCR4;
            K_FULLWB: burst = BU_INCR8;
            K_PLAIN: begin
                if (size != SZ_WORD)          burst = BU_SINGLE;
                else if (words_left >= EIGHT) burst = BU_INCR8;
                else if (words_left >= FOUR)  burst = BU_INCR4;
                else                          burst = BU_SINGLE;
            end
            default: burst = BU_SINGLE;
        endcase
    end
endmodule

// File: rtl/beat_stepper.sv
module beat_stepper
    import ahbsplit_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        size,
    input  logic              wrap,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int LINE_LSB = $clog2(LINE_BYTES);

    logic [ADDR_W-1:0]   step;
    logic [LINE_LSB-1:0] in_line;

    always_comb begin
        step      = ADDR_W'(1) << size;
        in_line   = cur_addr[LINE_LSB-1:0] + step[LINE_LSB-1:0];
        next_addr = wrap ? {cur_addr[ADDR_W-1:LINE_LSB], in_line}
                         : cur_addr + step;
    end
endmodule

// File: rtl/data_phase_tracker.sv
module data_phase_tracker #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic              beat_taken,
    input  logic              beat_write,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] hrdata,
    output logic              dph_active,
    output logic [DATA_W-1:0] hwdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic dph_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dph_active <= 1'b0;
            dph_write  <= 1'b0;
            hwdata     <= '0;
        end else if (hready) begin
            dph_active <= beat_taken;
            dph_write  <= beat_taken && beat_write;
            if (beat_taken && beat_write) hwdata <= wr_data;
        end
    end

    always_comb begin
        rd_valid = dph_active && !dph_write && hready;
        rd_data  = hrdata;
    end
endmodule

// File: rtl/burst_split_master.sv
module burst_split_master
    import ahbsplit_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_words,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [1:0]        req_kind,
    input  logic              req_fetch,
    input  logic [31:0]       wr_data,
    output logic              wr_pull,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hburst,
    output logic [2:0]        hsize,
    output logic              hwrite,
    output logic [31:0]       hwdata,
    input  logic [31:0]       hrdata,
    input  logic              hready
);
    localparam logic [CNT_W-1:0] ONE_WORD  = CNT_W'(1);
    localparam logic [CNT_W-1:0] HALF_LINE = CNT_W'(4);
    localparam logic [CNT_W-1:0] FULL_LINE = CNT_W'(8);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [2:0]        size_q;
    logic              write_q;
    kind_e             kind_q;
    burst_e            burst_q;
    logic [2:0]        beat_q;

    kind_e             in_kind;
    logic [2:0]        in_size;
    logic [CNT_W-1:0]  in_words;
    logic [ADDR_W-1:0] in_addr;

    logic [CNT_W-1:0]  plan_left;
    kind_e             plan_kind;
    logic [2:0]        plan_size;
    burst_e            plan_burst;

    logic [ADDR_W-1:0] step_addr;
    logic              accept_req;
    logic              beat_taken;
    logic              burst_end;
    logic              final_beat;
    logic              dph_active;

    // request decode: kind, effective size, beat count
    always_comb begin
        in_kind = kind_e'(req_kind);
        if (req_fetch || in_kind != K_PLAIN) in_size = SZ_WORD;
        else if (req_size == 2'd0)           in_size = SZ_BYTE;
        else if (req_size == 2'd1)           in_size = SZ_HALF;
        else                                 in_size = SZ_WORD;
        unique case (in_kind)
            K_FILL:   in_words = FULL_LINE;
            K_HALFWB: in_words = HALF_LINE;
            K_FULLWB: in_words = FULL_LINE;
            default:  in_words = (req_words == '0) ? ONE_WORD : req_words;
        endcase
    end

    addr_aligner #(.ADDR_W(ADDR_W)) u_align (
        .raw_addr     (req_addr),
        .size         (in_size),
        .aligned_addr (in_addr)
    );

    // one planner, fed by the new request when idle, else by the beats left
    always_comb begin
        if (state_q == ST_IDLE) begin
            plan_left = in_words;
            plan_kind = in_kind;
            plan_size = in_size;
        end else begin
            plan_left = left_q - ONE_WORD;
            plan_kind = kind_q;
            plan_size = size_q;
        end
    end

    burst_planner #(.CNT_W(CNT_W)) u_plan (
        .words_left (plan_left),
        .kind       (plan_kind),
        .size       (plan_size),
        .burst      (plan_burst)
    );

    beat_stepper #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_step (
        .cur_addr  (addr_q),
        .size      (size_q),
        .wrap      (burst_q == BU_WRAP8),
        .next_addr (step_addr)
    );

    data_phase_tracker #(.DATA_W(32)) u_dph (
        .clk        (clk),
        .rst_n      (rst_n),
        .hready     (hready),
        .beat_taken (beat_taken),
        .beat_write (write_q),
        .wr_data    (wr_data),
        .hrdata     (hrdata),
        .dph_active (dph_active),
        .hwdata     (hwdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    always_comb begin
        accept_req = (state_q == ST_IDLE) && req_valid;
        beat_taken = (state_q == ST_ADDR) && hready;
        burst_end  = (4'(beat_q) == burst_len(burst_q) - 4'd1);
        final_beat = (left_q == ONE_WORD);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_req) state_d = ST_ADDR;
            ST_ADDR:  if (beat_taken && final_beat) state_d = ST_DRAIN;
            ST_DRAIN: if (hready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            left_q  <= '0;
            size_q  <= SZ_WORD;
            write_q <= 1'b0;
            kind_q  <= K_PLAIN;
            burst_q <= BU_SINGLE;
            beat_q  <= '0;
        end else if (accept_req) begin
            addr_q  <= in_addr;
            left_q  <= in_words;
            size_q  <= in_size;
            write_q <= req_write;
            kind_q  <= in_kind;
            burst_q <= plan_burst;
            beat_q  <= '0;
        end else if (beat_taken) begin
            addr_q <= step_addr;
            left_q <= left_q - ONE_WORD;
            if (burst_end) begin
                beat_q  <= '0;
                burst_q <= plan_burst;
            end else begin
                beat_q <= beat_q + 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        haddr     = addr_q;
        hburst    = burst_q;
        hsize     = size_q;
        hwrite    = write_q;
        htrans    = TR_IDLE;
        if (state_q == ST_ADDR)
            htrans = (beat_q == '0) ? TR_NONSEQ : TR_SEQ;
        wr_pull   = beat_taken && write_q;
        done      = (state_q == ST_DRAIN) && hready && dph_active;
    end
endmodule

// File: rtl/ahb_split_chk.sv
module ahb_split_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              wr_pull,
    input logic              rd_valid,
    input logic              done,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic [2:0]        hburst,
    input logic [2:0]        hsize,
    input logic              hwrite,
    input logic [31:0]       hwdata,
    input logic              hready
);
    logic ph_busy, ph_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_busy <= 1'b0;
            ph_wr   <= 1'b0;
        end else if (hready) begin
            ph_busy <= htrans[1];
            ph_wr   <= htrans[1] && hwrite;
        end
    end

    // R9
    hold_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans[1] && !hready) |=> ($stable(haddr) && $stable(htrans) &&
            $stable(hburst) && $stable(hsize) && $stable(hwrite)));

    // R9
    hold_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_wr && !hready) |=> $stable(hwdata));

    // R10
    done_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hready && ph_busy && !htrans[1]));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (htrans == 2'b00 && !ph_busy));

    // R6
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans[1] && hsize == 3'b001) |-> !haddr[0]);

    // R6
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans[1] && hsize == 3'b010) |-> (haddr[1:0] == 2'b00));

    // R7
    narrow_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans[1] && hsize != 3'b010) |-> (hburst == 3'b000));

    // R2
    burst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        htrans[1] |-> (hburst == 3'b000 || hburst == 3'b011 ||
                       hburst == 3'b100 || hburst == 3'b101));

    // R3
    seq_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> (hburst != 3'b000));

    // R11
    pull_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pull |-> (htrans[1] && hready && hwrite));

    // R12
    rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (hready && ph_busy && !ph_wr));
endmodule

bind burst_split_master ahb_split_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .wr_pull   (wr_pull),
    .rd_valid  (rd_valid),
    .done      (done),
    .haddr     (haddr),
    .htrans    (htrans),
    .hburst    (hburst),
    .hsize     (hsize),
    .hwrite    (hwrite),
    .hwdata    (hwdata),
    .hready    (hready)
);

// File: tb/sim_burst_split_master.sv
module sim_burst_split_master;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 8;

    typedef struct packed {
        logic [31:0] a;
        logic [1:0]  t;
        logic [2:0]  b;
        logic [2:0]  s;
        logic        w;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_words = '0;
    logic [1:0]    req_size = 2'd2;
    logic          req_write = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic          req_fetch = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          wr_pull;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          done;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic [2:0]    hburst;
    logic [2:0]    hsize;
    logic          hwrite;
    logic [31:0]   hwdata;
    logic [31:0]   hrdata = '0;
    logic          hready = 1'b1;

    int    tests = 0;
    int    fails = 0;
    int    done_cnt = 0;
    int    widx = 0;
    bit    pull_seen = 0;
    bit    waits_on = 0;
    logic [7:0] lfsr = 8'h5B;
    string cur_tag = "R1";
    beat_t exq[$];

    bit          dv = 0;
    bit          dw = 0;
    logic [31:0] da = '0;
    logic [31:0] dwexp = '0;
    bit          stalled = 0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_trans = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_split_master #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_words(req_words), .req_size(req_size),
        .req_write(req_write), .req_kind(req_kind), .req_fetch(req_fetch),
        .wr_data(wr_data), .wr_pull(wr_pull), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done), .haddr(haddr), .htrans(htrans),
        .hburst(hburst), .hsize(hsize), .hwrite(hwrite), .hwdata(hwdata),
        .hrdata(hrdata), .hready(hready)
    );

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected beat list, built from the requirements
    task automatic plan_beats(input logic [31:0] addr, input int words,
                              input int size, input bit wr, input int kind,
                              input bit fetch);
        int sz;
        int n;
        logic [31:0] a;
        beat_t bt;
        sz = (fetch || kind != 0) ? 2 : ((size >= 2) ? 2 : size);
        a = (sz == 2) ? {addr[31:2], 2'b00} : (sz == 1) ? {addr[31:1], 1'b0} : addr;
        if (kind == 1) begin
            for (int i = 0; i < 8; i++) begin
                bt.a = {a[31:5], 5'(a[4:0] + 5'(4 * i))};
                bt.t = (i == 0) ? 2'b10 : 2'b11;
                bt.b = 3'b100; bt.s = 3'(sz); bt.w = wr;
                exq.push_back(bt);
            end
        end else begin
            n = (kind == 2) ? 4 : (kind == 3) ? 8 : ((words == 0) ? 1 : words);
            while (n > 0) begin
                int len;
                logic [2:0] bu;
                if (kind == 2)                 begin len = 4; bu = 3'b011; end
                else if (kind == 3)            begin len = 8; bu = 3'b101; end
                else if (sz != 2)              begin len = 1; bu = 3'b000; end
                else if (n >= 8)               begin len = 8; bu = 3'b101; end
                else if (n >= 4)               begin len = 4; bu = 3'b011; end
                else                           begin len = 1; bu = 3'b000; end
                for (int j = 0; j < len; j++) begin
                    bt.a = a; bt.t = (j == 0) ? 2'b10 : 2'b11;
                    bt.b = bu; bt.s = 3'(sz); bt.w = wr;
                    exq.push_back(bt);
                    a = a + (32'd1 << sz);
                end
                n -= len;
            end
        end
    endtask

    // driver: pushes the expected beats, then issues the request
    task automatic do_req(input logic [31:0] addr, input int words, input int size,
                          input bit wr, input int kind, input bit fetch,
                          input bit waits, input string tag);
        int start;
        int guard;
        @(negedge clk);
        cur_tag = tag;
        waits_on = waits;
        plan_beats(addr, words, size, wr, kind, fetch);
        start = done_cnt;
        req_addr = addr; req_words = CW'(words); req_size = 2'(size);
        req_write = wr; req_kind = 2'(kind); req_fetch = fetch;
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "req_ready while busy", 64'(req_ready), 64'd0);
        guard = 0;
        while (done_cnt == start && guard < 2000) begin
            @(posedge clk);
            guard++;
        end
        if (done_cnt == start) begin
            check(1'b0, tag, "request never completed", 64'd0, 64'd1);
            exq.delete();
        end
        @(negedge clk);
        #2;
        check(exq.size() == 0, tag, "beats left unissued", 64'(exq.size()), 64'd0);
        check(req_ready == 1'b1, "R10", "req_ready after done", 64'(req_ready), 64'd1);
    endtask

    // slave model and monitor
    initial begin
        forever begin
            @(negedge clk);
            if (pull_seen) widx++;
            pull_seen = 0;
            wr_data = 32'hC0DE_0000 + 32'(widx);
            hrdata = dv ? rd_word(da) : 32'h0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            hready = waits_on ? (lfsr[1:0] != 2'b00) : 1'b1;
            #1;
            if (rst_n) begin
                bit completing;
                completing = dv && hready;
                if (stalled) begin
                    check(haddr == st_addr && htrans == st_trans, "R9",
                          "held address moved", {32'h0, haddr}, {32'h0, st_addr});
                end
                stalled = htrans[1] && !hready;
                st_addr = haddr;
                st_trans = htrans;
                if (completing) begin
                    if (dw) begin
                        check(hwdata == dwexp, "R11", "hwdata", 64'(hwdata), 64'(dwexp));
                        check(rd_valid == 1'b0, "R12", "rd_valid on write", 64'(rd_valid), 64'd0);
                    end else begin
                        check(rd_valid == 1'b1 && rd_data == rd_word(da), "R12", "read data",
                              {31'h0, rd_valid, rd_data}, {32'h1, rd_word(da)});
                    end
                end
                if (completing || done) begin
                    bit exp_done;
                    exp_done = completing && (exq.size() == 0);
                    check(done == exp_done, "R10", "done", 64'(done), 64'(exp_done));
                    if (done) done_cnt++;
                end
                if (htrans[1] && hready) begin
                    if (exq.size() == 0) begin
                        check(1'b0, cur_tag, "unexpected beat", {32'h0, haddr}, 64'd0);
                    end else begin
                        beat_t e;
                        e = exq.pop_front();
                        check(haddr == e.a && htrans == e.t && hburst == e.b &&
                              hsize == e.s && hwrite == e.w, cur_tag, "address beat",
                              {23'h0, hburst, hsize, htrans, hwrite, haddr},
                              {23'h0, e.b, e.s, e.t, e.w, e.a});
                    end
                    check(wr_pull == hwrite, "R11", "wr_pull", 64'(wr_pull), 64'(hwrite));
                    dv = 1; dw = hwrite; da = haddr; dwexp = wr_data;
                    if (wr_pull) pull_seen = 1;
                end else if (hready) begin
                    dv = 0;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(htrans == 2'b00 && req_ready && !done, "R1", "reset state",
              {61'h0, htrans, req_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(htrans == 2'b00 && req_ready && !done, "R1", "state after reset",
              {61'h0, htrans, req_ready}, 64'd1);
        do_req(32'h0000_0100, 13, 2, 0, 0, 0, 0, "R2");   // INCR8 + INCR4 + SINGLE
        do_req(32'h0000_0041,  5, 2, 1, 0, 0, 1, "R6");   // aligned to 0x40, INCR4 + SINGLE
        do_req(32'h0000_0114,  3, 2, 0, 1, 0, 1, "R4");   // WRAP8 from critical word
        do_req(32'h0000_0206,  1, 2, 1, 2, 0, 1, "R5");   // half-line write-back
        do_req(32'h0000_0300,  3, 2, 1, 3, 0, 0, "R5");   // full-line write-back
        do_req(32'h0000_0351,  3, 1, 1, 0, 0, 1, "R7");   // halfword singles
        do_req(32'h0000_0403,  2, 0, 0, 0, 0, 0, "R7");   // byte singles
        do_req(32'h0000_0502,  2, 0, 0, 0, 1, 1, "R8");   // fetch forces word size
        do_req(32'h0000_0600,  0, 2, 0, 0, 0, 0, "R13");  // zero count
        do_req(32'h0000_0700,  8, 2, 0, 0, 0, 1, "R9");   // INCR8 with wait states
        do_req(32'h0000_0800, 16, 2, 1, 0, 0, 1, "R3");   // two INCR8, NONSEQ per burst
        do_req(32'h0000_09F8,  6, 2, 0, 0, 0, 0, "R2");   // INCR4 + two SINGLE
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule